// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers eight interrupt lines and presents one interrupt request to a processor. Each line can be masked. Lines are ranked in a priority order that software can rotate. A line that is being serviced blocks every line of equal or lower rank until software ends its service, unless the controller was set up to end service automatically. The processor answers the interrupt with a one-cycle acknowledge strobe. In that same cycle the block returns an eight-bit vector built from a programmed base and the winning line number.

Software programs the block through a byte port with two addresses. Address 0 restarts programming, carries run-time commands and reads the pending or in-service set. Address 1 takes the setup bytes in a fixed order and afterwards holds the mask.

Two instances can be chained to serve sixteen lines. The second instance, in slave role, drives its interrupt output into one line of the master. When the master acknowledges that line, it names the line on its cascade outputs, and the matching slave supplies the vector instead of the master.

Top module: `pic_ctrl`

## Requirements
- R1: After reset `int_out` is 0, address 1 reads 8'hFF and address 0 reads 8'h00.
- R2: A write to address 0 with bit 4 set starts setup. Bit 0 of that byte asks for a mode byte. The setup clears the mask and the in-service set, sets lowest priority to line 7 and selects the pending-set readback. The next address-1 writes are taken in this order: the base, then the cascade byte, then the mode byte if it was asked for. Only after that do address-1 writes load the mask. `int_out` stays 0 while setup is in progress.
- R3: An acknowledge returns the vector {base[7:3], line number}, with `vec_en` high only during `inta`.
- R4: Address-0 byte 3'b110 in bits 7:5 makes the line in bits 2:0 the lowest priority. The remaining lines follow in ascending order from the line after it, wrapping round. Right after setup the order is 0 (highest) to 7 (lowest).
- R5: `int_out` is 1 only when an unmasked pending line outranks every line in service.
- R6: A masked line never raises `int_out`, but it still shows in the pending-set readback.
- R7: Address-0 byte 3'b001 in bits 7:5 (bits 4:3 zero) clears the in-service bit of highest current priority.
- R8: An address-0 write with bit 4 clear, bit 3 set and bit 1 set selects the readback at address 0: bit 0 = 1 gives the in-service set, bit 0 = 0 gives the pending set. The choice lasts until it is changed again or setup restarts.
- R9: Mode-byte bit 1 enables automatic end of service. An acknowledge then sets no in-service bit.
- R10: If no eligible request is present at an acknowledge, the vector of line 7 is returned and no in-service bit is set.
- R11: An edge line (its `lvl_sel` bit 0) latches a rising edge into the pending set until it is acknowledged or setup restarts. A level line (`lvl_sel` bit 1) is pending only while its input is high.
- R12: Mode-byte bit 2 selects slave role. The master's cascade byte marks the lines that carry slaves, and the slave's cascade byte holds the master line number it hangs on. Acknowledging a slave line sets `cas_act`, puts the line on `cas_out` and keeps `vec_en` low. The slave whose number matches returns its own vector and marks its own in-service bit, while the master marks the slave line in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register address (0 command, 1 setup/mask) |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for the current address |
| irq_in | input | 8 | Interrupt request lines |
| lvl_sel | input | 8 | Per-line trigger select, 1 = level |
| int_out | output | 1 | Interrupt request to the processor or master |
| inta | input | 1 | One-cycle acknowledge strobe |
| vec_out | output | 8 | Vector returned during acknowledge |
| vec_en | output | 1 | This instance drives the vector |
| cas_in | input | 3 | Line number named by the master (slave role) |
| cas_sel | input | 1 | Master is acknowledging a slave line (slave role) |
| cas_out | output | 3 | Line number of the acknowledged slave line (master role) |
| cas_act | output | 1 | Master hands this acknowledge to a slave |

## Verification
The priority resolver is swept over all eight lowest-priority settings. Each setting gets several request sets: all lines, the two end lines, solid middle blocks and alternating bits. Each set is drained one acknowledge at a time, so the order of vectors shows where the rotation starts and how it wraps. Nested service is exercised with a higher line arriving over a lower one and a lower line waiting behind it, which separates the in-service block from plain request ranking. Other stimuli tell the remaining modes apart: a level line dropped before acknowledge (spurious vector), a short edge pulse (latched request) and automatic end of service. A chained slave line is compared with a direct master line, to show which instance answers.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NLINES = 8;
    localparam int LVL_W  = $clog2(NLINES);
    localparam int DW     = 8;
    localparam int BASE_W = DW - LVL_W;

    typedef logic [NLINES-1:0] line_vec_t;
    typedef logic [LVL_W-1:0]  lvl_t;

    typedef enum logic [1:0] {PH_RUN, PH_BASE, PH_CASC, PH_MODE} init_ph_t;

    typedef struct packed {
        logic [BASE_W-1:0] base_hi;
        line_vec_t         casc;
        logic              aeoi;
        logic              is_slave;
        lvl_t              lowest;
        logic              show_isr;
        line_vec_t         imr;
    } pic_cfg_t;

    typedef struct packed {
        logic found;
        lvl_t idx;
    } pick_t;

    // command byte fields at address 0
    localparam int CW_INIT      = 4;
    localparam int CW_NEED_MODE = 0;
    localparam int CW_RSEL      = 3;
    localparam int CW_RSEL_ACT  = 1;
    localparam int CW_RSEL_ISR  = 0;
    localparam logic [2:0] OP_NS_EOI  = 3'b001;
    localparam logic [2:0] OP_SET_LOW = 3'b110;
    // mode byte fields
    localparam int MW_AEOI  = 1;
    localparam int MW_SLAVE = 2;

    // highest-ranked set bit, scanning upward from the line after 'low'
    function automatic pick_t pick_top(line_vec_t v, lvl_t low);
        pick_t r;
        lvl_t  idx;
        r = '0;
        for (int k = 0; k < NLINES; k++) begin
            idx = low + lvl_t'(k + 1);
            if (!r.found && v[idx]) begin
                r.found = 1'b1;
                r.idx   = idx;
            end
        end
        return r;
    endfunction

    // 0 = highest rank
    function automatic lvl_t rank_of(lvl_t idx, lvl_t low);
        return idx - low - lvl_t'(1);
    endfunction

    function automatic line_vec_t bit_of(lvl_t idx);
        return line_vec_t'(1) << idx;
    endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] wr_data,
    output pic_cfg_t      cfg,
    output logic          busy,
    output logic          init_pulse,
    output logic          eoi_pulse
);
    init_ph_t ph_q;
    logic     need_mode_q;
    pic_cfg_t cfg_q;

    logic is_cmd;
    assign is_cmd = wr_en && !addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q           <= PH_RUN;
            need_mode_q    <= 1'b0;
            cfg_q.base_hi  <= '0;
            cfg_q.casc     <= '0;
            cfg_q.aeoi     <= 1'b0;
            cfg_q.is_slave <= 1'b0;
            cfg_q.lowest   <= '1;
            cfg_q.show_isr <= 1'b0;
            cfg_q.imr      <= '1;
        end else if (is_cmd) begin
            if (wr_data[CW_INIT]) begin
                ph_q           <= PH_BASE;
                need_mode_q    <= wr_data[CW_NEED_MODE];
                cfg_q.imr      <= '0;
                cfg_q.lowest   <= '1;
                cfg_q.show_isr <= 1'b0;
                cfg_q.aeoi     <= 1'b0;
                cfg_q.is_slave <= 1'b0;
            end else if (ph_q == PH_RUN) begin
                if (wr_data[CW_RSEL]) begin
                    if (wr_data[CW_RSEL_ACT])
                        cfg_q.show_isr <= wr_data[CW_RSEL_ISR];
                end else if (wr_data[7:5] == OP_SET_LOW) begin
                    cfg_q.lowest <= wr_data[LVL_W-1:0];
                end
            end
        end else if (wr_en) begin
            unique case (ph_q)
                PH_BASE: begin
                    cfg_q.base_hi <= wr_data[DW-1:LVL_W];
                    ph_q          <= PH_CASC;
                end
                PH_CASC: begin
                    cfg_q.casc <= wr_data;
                    ph_q       <= need_mode_q ? PH_MODE : PH_RUN;
                end
                PH_MODE: begin
                    cfg_q.aeoi     <= wr_data[MW_AEOI];
                    cfg_q.is_slave <= wr_data[MW_SLAVE];
                    ph_q           <= PH_RUN;
                end
                default: cfg_q.imr <= wr_data;
            endcase
        end
    end

    assign cfg        = cfg_q;
    assign busy       = (ph_q != PH_RUN);
    assign init_pulse = is_cmd && wr_data[CW_INIT];
    assign eoi_pulse  = is_cmd && !busy && !wr_data[CW_INIT] && !wr_data[CW_RSEL]
                        && (wr_data[7:5] == OP_NS_EOI);
endmodule

// File: rtl/pic_irr.sv
module pic_irr
    import pic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t irq_in,
    input  line_vec_t lvl_sel,
    input  line_vec_t clr,
    input  logic      flush,
    output line_vec_t irr
);
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic prev_q;
        logic req_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                req_q  <= 1'b0;
            end else begin
                prev_q <= irq_in[g];
                if (lvl_sel[g])
                    req_q <= irq_in[g];
                else
                    req_q <= (req_q && !clr[g] && !flush) || (irq_in[g] && !prev_q);
            end
        end
        assign irr[g] = req_q;
    end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  addr,
    input  logic [7:0]            wr_data,
    output logic [7:0]            rd_data,
    input  logic [7:0]            irq_in,
    input  logic [7:0]            lvl_sel,
    output logic                  int_out,
    input  logic                  inta,
    output logic [7:0]            vec_out,
    output logic                  vec_en,
    input  logic [2:0]            cas_in,
    input  logic                  cas_sel,
    output logic [2:0]            cas_out,
    output logic                  cas_act
);
    pic_cfg_t  cfg;
    logic      busy, init_pulse, eoi_pulse;
    line_vec_t irr, isr_q, eligible, set_bit, eoi_clr;
    pick_t     req, svc;
    logic      outranks, ack_hit, real_ack, to_slave;
    lvl_t      vec_idx;
    line_vec_t imr_w;
    logic      aeoi_w;

    pic_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .cfg(cfg), .busy(busy), .init_pulse(init_pulse), .eoi_pulse(eoi_pulse)
    );

    pic_irr u_irr (
        .clk(clk), .rst(rst), .irq_in(irq_in), .lvl_sel(lvl_sel),
        .clr(set_bit), .flush(init_pulse), .irr(irr)
    );

    assign eligible = irr & ~cfg.imr;
    assign req      = pick_top(eligible, cfg.lowest);
    assign svc      = pick_top(isr_q, cfg.lowest);
    assign outranks = req.found &&
                      (!svc.found || (rank_of(req.idx, cfg.lowest) < rank_of(svc.idx, cfg.lowest)));

    assign int_out  = outranks && !busy;
    assign ack_hit  = !busy && inta &&
                      (!cfg.is_slave || (cas_sel && (cas_in == cfg.casc[LVL_W-1:0])));
    assign real_ack = ack_hit && outranks;
    assign to_slave = !cfg.is_slave && cfg.casc[req.idx];

    assign cas_act  = real_ack && to_slave;
    assign cas_out  = cas_act ? req.idx : '0;
    assign vec_en   = ack_hit && !cas_act;
    assign vec_idx  = real_ack ? req.idx : lvl_t'(NLINES - 1);
    assign vec_out  = vec_en ? {cfg.base_hi, vec_idx} : '0;

    assign set_bit  = real_ack ? bit_of(req.idx) : '0;
    assign eoi_clr  = (eoi_pulse && svc.found) ? bit_of(svc.idx) : '0;

    always_ff @(posedge clk) begin
        if (rst || init_pulse)
            isr_q <= '0;
        else
            isr_q <= (isr_q & ~eoi_clr) | (cfg.aeoi ? '0 : set_bit);
    end

    assign rd_data = addr ? cfg.imr : (cfg.show_isr ? isr_q : irr);
    assign imr_w   = cfg.imr;
    assign aeoi_w  = cfg.aeoi;
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       int_out,
    input logic       inta,
    input logic       vec_en,
    input logic       cas_act,
    input logic       busy,
    input logic [7:0] isr,
    input logic [7:0] irr,
    input logic [7:0] imr,
    input logic       aeoi
);
    // R2
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !int_out);

    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((irr & ~imr) != 8'h00));

    // R3
    vec_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
        vec_en |-> inta);

    // R9
    isr_from_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ((isr & ~$past(isr)) != 8'h00) |-> ($past(inta) && !$past(aeoi)));

    // R5
    one_new_isr_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(isr & ~$past(isr)));

    // R12
    cascade_handoff_chk: assert property (@(posedge clk) disable iff (rst)
        cas_act |-> (!vec_en && inta));
endmodule

bind pic_ctrl pic_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .int_out(int_out), .inta(inta), .vec_en(vec_en),
    .cas_act(cas_act), .busy(busy), .isr(isr_q), .irr(irr), .imr(imr_w), .aeoi(aeoi_w)
);

// File: tb/pic_ctrl_tb_top.sv
module pic_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       m_wr = 1'b0, s_wr = 1'b0;
    logic       inta = 1'b0;
    logic       cas_mode = 1'b0;
    logic [7:0] b_irq = 8'h00, s_irq = 8'h00;
    logic [7:0] m_lvl = 8'h00;
    logic [7:0] m_rd, s_rd, m_vec, s_vec, m_irq;
    logic       m_int, s_int, m_vec_en, s_vec_en, m_cas_act, s_cas_act;
    logic [2:0] m_cas_out, s_cas_out;
    logic       s_inta;
    int         n_chk = 0, n_err = 0;

    always #10 clk = ~clk;

    assign m_irq  = cas_mode ? {b_irq[7:3], s_int, b_irq[1:0]} : b_irq;
    assign s_inta = inta && cas_mode;

    pic_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(m_wr), .addr(addr), .wr_data(wdata), .rd_data(m_rd),
        .irq_in(m_irq), .lvl_sel(m_lvl), .int_out(m_int), .inta(inta),
        .vec_out(m_vec), .vec_en(m_vec_en), .cas_in(3'd0), .cas_sel(1'b0),
        .cas_out(m_cas_out), .cas_act(m_cas_act)
    );

    pic_ctrl slave_i (
        .clk(clk), .rst(rst), .wr_en(s_wr), .addr(addr), .wr_data(wdata), .rd_data(s_rd),
        .irq_in(s_irq), .lvl_sel(8'h00), .int_out(s_int), .inta(s_inta),
        .vec_out(s_vec), .vec_en(s_vec_en), .cas_in(m_cas_out), .cas_sel(m_cas_act),
        .cas_out(s_cas_out), .cas_act(s_cas_act)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input int dev, input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (dev == 0) m_wr = 1'b1; else s_wr = 1'b1;
        @(negedge clk);
        m_wr = 1'b0; s_wr = 1'b0;
    endtask

    task automatic rd(input int dev, input logic a, output logic [7:0] d);
        addr = a;
        #2;
        d = (dev == 0) ? m_rd : s_rd;
    endtask

    task automatic setup(input int dev, input logic [7:0] base, input logic [7:0] casc,
                         input logic [7:0] mode);
        wr(dev, 1'b0, 8'h11);
        wr(dev, 1'b1, base);
        wr(dev, 1'b1, casc);
        wr(dev, 1'b1, mode);
    endtask

    task automatic ack(output logic [7:0] v, output logic men, output logic sen,
                       output logic cact);
        inta = 1'b1;
        #2;
        men = m_vec_en; sen = s_vec_en; cact = m_cas_act;
        v = m_vec_en ? m_vec : s_vec;
        @(negedge clk);
        inta = 1'b0;
    endtask

    task automatic pulse_m(input logic [7:0] m);
        b_irq = b_irq | m;
        @(negedge clk);
        b_irq = b_irq & ~m;
        @(negedge clk);
    endtask

    function automatic int top_of(logic [7:0] p, int low);
        for (int k = 0; k < 8; k++) begin
            int i;
            i = (low + 1 + k) % 8;
            if (p[i]) return i;
        end
        return -1;
    endfunction

    function automatic logic [7:0] pat_of(int i);
        case (i)
            0: return 8'hFF;
            1: return 8'h81;
            2: return 8'h3C;
            3: return 8'h42;
            4: return 8'h55;
            default: return 8'hAA;
        endcase
    endfunction

    initial begin
        #(20 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v, d;
        logic men, sen, cact;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 int", {7'd0, m_int}, 8'h00);
        rd(0, 1'b1, d); chk("R1 mask", d, 8'hFF);
        rd(0, 1'b0, d); chk("R1 pending", d, 8'h00);

        // R2 setup without mode byte: third write lands in mask
        wr(0, 1'b0, 8'h10);
        chk("R2 quiet in setup", {7'd0, m_int}, 8'h00);
        rd(0, 1'b1, d); chk("R2 mask cleared", d, 8'h00);
        wr(0, 1'b1, 8'h40);
        wr(0, 1'b1, 8'h00);
        rd(0, 1'b1, d); chk("R2 base/casc not mask", d, 8'h00);
        wr(0, 1'b1, 8'h5A);
        rd(0, 1'b1, d); chk("R2 mask after setup", d, 8'h5A);

        // R2 with mode byte
        setup(0, 8'h40, 8'h00, 8'h00);
        rd(0, 1'b1, d); chk("R2 mode byte consumed", d, 8'h00);

        // R6 masked line, R8 default pending readback
        wr(0, 1'b1, 8'h20);
        pulse_m(8'h20);
        chk("R6 masked no int", {7'd0, m_int}, 8'h00);
        rd(0, 1'b0, d); chk("R6 R8 pending shows masked", d, 8'h20);
        wr(0, 1'b0, 8'h0B);
        rd(0, 1'b0, d); chk("R8 in-service view", d, 8'h00);
        wr(0, 1'b0, 8'h0A);
        rd(0, 1'b0, d); chk("R8 back to pending", d, 8'h20);
        wr(0, 1'b1, 8'h00);
        chk("R6 unmasked int", {7'd0, m_int}, 8'h01);
        ack(v, men, sen, cact); chk("R3 vector line 5", v, 8'h45);
        wr(0, 1'b0, 8'h20);

        // R3 R4 sweep over all lowest levels
        for (int lv = 0; lv < 8; lv++) begin
            wr(0, 1'b0, 8'hC0 | 8'(lv));
            for (int pi = 0; pi < 6; pi++) begin
                logic [7:0] left;
                left = pat_of(pi);
                pulse_m(left);
                while (left != 8'h00) begin
                    int w;
                    w = top_of(left, lv);
                    chk("R5 int while pending", {7'd0, m_int}, 8'h01);
                    ack(v, men, sen, cact);
                    chk("R4 R3 sweep order", v, 8'(8'h40 + w));
                    left[w] = 1'b0;
                    wr(0, 1'b0, 8'h20);
                end
                chk("R4 drained", {7'd0, m_int}, 8'h00);
            end
        end
        wr(0, 1'b0, 8'hC7);

        // R5 nesting, R7 EOI
        wr(0, 1'b0, 8'h0B);
        pulse_m(8'h08);
        ack(v, men, sen, cact); chk("R5 first", v, 8'h43);
        pulse_m(8'h20);
        chk("R5 lower blocked", {7'd0, m_int}, 8'h00);
        pulse_m(8'h02);
        chk("R5 higher passes", {7'd0, m_int}, 8'h01);
        ack(v, men, sen, cact); chk("R5 nested", v, 8'h41);
        rd(0, 1'b0, d); chk("R8 persists", d, 8'h0A);
        wr(0, 1'b0, 8'h20);
        rd(0, 1'b0, d); chk("R7 clears highest", d, 8'h08);
        chk("R5 still blocked", {7'd0, m_int}, 8'h00);
        wr(0, 1'b0, 8'h20);
        chk("R5 released", {7'd0, m_int}, 8'h01);
        ack(v, men, sen, cact); chk("R5 waiting line", v, 8'h45);
        wr(0, 1'b0, 8'h20);

        // R7 under rotation (lowest 3)
        wr(0, 1'b0, 8'hC3);
        pulse_m(8'h01);
        ack(v, men, sen, cact); chk("R4 rotated single", v, 8'h40);
        pulse_m(8'h20);
        ack(v, men, sen, cact); chk("R4 rotated nest", v, 8'h45);
        wr(0, 1'b0, 8'h20);
        rd(0, 1'b0, d); chk("R7 rotated clear", d, 8'h01);
        wr(0, 1'b0, 8'h20);
        rd(0, 1'b0, d); chk("R7 empty", d, 8'h00);

        // R9 automatic end of service
        setup(0, 8'h40, 8'h00, 8'h02);
        wr(0, 1'b0, 8'h0B);
        pulse_m(8'h40);
        ack(v, men, sen, cact); chk("R9 vector", v, 8'h46);
        rd(0, 1'b0, d); chk("R9 no in-service", d, 8'h00);
        chk("R9 no int", {7'd0, m_int}, 8'h00);

        // R8 default after setup
        setup(0, 8'h40, 8'h00, 8'h00);
        pulse_m(8'h40);
        rd(0, 1'b0, d); chk("R8 default pending", d, 8'h40);
        ack(v, men, sen, cact);
        wr(0, 1'b0, 8'h20);

        // R11 level, R10 spurious
        m_lvl = 8'h01;
        b_irq[0] = 1'b1;
        @(negedge clk);
        chk("R11 level int", {7'd0, m_int}, 8'h01);
        rd(0, 1'b0, d); chk("R11 level pending", d, 8'h01);
        b_irq[0] = 1'b0;
        @(negedge clk);
        rd(0, 1'b0, d); chk("R11 level gone", d, 8'h00);
        ack(v, men, sen, cact); chk("R10 spurious vector", v, 8'h47);
        wr(0, 1'b0, 8'h0B);
        rd(0, 1'b0, d); chk("R10 no in-service", d, 8'h00);
        wr(0, 1'b0, 8'h0A);
        pulse_m(8'h40);
        rd(0, 1'b0, d); chk("R11 edge latched", d, 8'h40);
        ack(v, men, sen, cact); chk("R11 edge vector", v, 8'h46);
        rd(0, 1'b0, d); chk("R11 cleared by ack", d, 8'h00);
        wr(0, 1'b0, 8'h20);
        m_lvl = 8'h00;

        // R12 cascade
        cas_mode = 1'b1;
        m_lvl = 8'h04;
        setup(0, 8'h40, 8'h04, 8'h00);
        setup(1, 8'h70, 8'h02, 8'h04);
        wr(0, 1'b0, 8'h0B);
        wr(1, 1'b0, 8'h0B);
        s_irq = 8'h08;
        @(negedge clk);
        s_irq = 8'h00;
        @(negedge clk);
        chk("R12 master int", {7'd0, m_int}, 8'h01);
        ack(v, men, sen, cact);
        chk("R12 slave vector", v, 8'h73);
        chk("R12 master silent", {7'd0, men}, 8'h00);
        chk("R12 handoff", {7'd0, cact}, 8'h01);
        rd(0, 1'b0, d); chk("R12 master in-service", d, 8'h04);
        rd(1, 1'b0, d); chk("R12 slave in-service", d, 8'h08);
        wr(1, 1'b0, 8'h20);
        rd(1, 1'b0, d); chk("R12 slave cleared", d, 8'h00);
        wr(0, 1'b0, 8'h20);
        rd(0, 1'b0, d); chk("R12 master cleared", d, 8'h00);
        pulse_m(8'h20);
        ack(v, men, sen, cact);
        chk("R12 direct line vector", v, 8'h45);
        chk("R12 slave stays off", {7'd0, sen}, 8'h00);
        wr(0, 1'b0, 8'h20);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule